// File: doc/BRIEF.md
# Next-PC and Branch Unit

This block decides where a 32-bit RISC core with fixed 4-byte instructions fetches next. Each cycle the decoder presents the current program counter, a control-flow class, a branch condition, the 16-bit and 26-bit immediates, three register indices, the two source operand values and the three link registers (return address, exception return address and break return address). One cycle later the unit presents the next PC, a taken flag, a one-hot classification of the control flow and an optional write to the register file that carries a link address.

Direct jumps keep the top four bits of the current PC and insert a word-aligned 26-bit target below them. PC-relative branches add a sign-extended 16-bit offset, with its two low bits cleared, to the address of the following instruction. Register-indirect forms take the target from a source operand or from one of the link registers. An exception return also raises a strobe that tells the status logic to restore its saved copy.

Top module: `npc_unit`

## Requirements
- R1: The outputs are registered: an input sampled with `in_valid` high at one rising edge appears with `out_valid` high after that edge. Class codes 0 (plain) and 11 to 15 give `npc` = `pc`+4, `taken` low and no link write.
- R2: Class 1 (direct jump) gives `npc` = (`pc` AND 0xF000_0000) OR (`imm_j` shifted left by 2), with `taken` high and no link write.
- R3: Class 2 (direct call) redirects exactly as class 1 and writes `pc`+4 to register 31.
- R4: Class 3 (unconditional branch) gives `npc` = `pc`+4 plus the sign-extended `imm_b` with its two low bits cleared, always taken.
- R5: Class 4 (conditional branch) compares operand A with operand B under `cond`: 0 signed greater-or-equal, 1 signed less, 2 not equal, 3 equal, 4 unsigned greater-or-equal, 5 unsigned less; codes 6 and 7 are never true. A true condition takes the R4 target, a false one gives `pc`+4 with `taken` low.
- R6: Classes 7, 8 and 9 load `npc` from `ra_val`, `ea_val` and `ba_val` respectively, taken. Only class 8 raises `status_restore`.
- R7: Class 5 (register jump) loads `npc` from operand A; class 6 (register call) does the same and writes `pc`+4 to register 31.
- R8: Class 10 writes `pc`+4 to register `idx_c`, with `npc` = `pc`+4 and `taken` low.
- R9: A link write whose destination index is 0 is suppressed (`link_we` stays low).
- R10: When `idx_a` or `idx_b` is 0, the corresponding operand is treated as zero, both for branch comparison and for register-indirect targets.
- R11: `kind` is one-hot while `out_valid` is high: bit 0 sequential (classes 0, 10, 11-15), bit 1 branch (3, 4, taken or not), bit 2 jump (1, 2, 5, 6), bit 3 return (7, 8, 9). With `out_valid` low, `taken`, `link_we` and `status_restore` are low.
- R12: Synchronous reset clears every output to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction fields are valid this cycle |
| op | input | 4 | Control-flow class code |
| cond | input | 3 | Branch condition code |
| pc | input | 32 | Address of the current instruction |
| imm_b | input | 16 | Branch offset immediate |
| imm_j | input | 26 | Direct jump word index |
| idx_a | input | 5 | Register index of operand A |
| idx_b | input | 5 | Register index of operand B |
| idx_c | input | 5 | Destination index for the PC capture class |
| opnd_a | input | 32 | Value read for operand A |
| opnd_b | input | 32 | Value read for operand B |
| ra_val | input | 32 | Return address register |
| ea_val | input | 32 | Exception return address register |
| ba_val | input | 32 | Break return address register |
| out_valid | output | 1 | Outputs below are valid |
| npc | output | 32 | Next program counter |
| taken | output | 1 | Control flow leaves the sequential path |
| kind | output | 4 | One-hot flow class |
| link_we | output | 1 | Register write request |
| link_idx | output | 5 | Register write index |
| link_val | output | 32 | Register write value |
| status_restore | output | 1 | Restore status from its saved copy |

## Verification
The condition logic is swept over every condition code against every ordered pair of a corner-value set (0, 1, all ones, the most positive and most negative values, a small positive); the pairs separate signed from unsigned ordering and equal from unequal inputs. Every class code is applied across PCs that differ in their top nibble and sit near the end of the address space, with branch immediates that are positive, negative, misaligned and at both extremes, so target wrap-around, nibble splicing and low-bit clearing are each exposed. Zero register indices are crossed with nonzero operand values and destinations to show operand zeroing and write suppression.

// File: rtl/npc_pkg.sv
package npc_pkg;
  typedef enum logic [3:0] {
    CF_PLAIN = 4'd0,
    CF_JDIR  = 4'd1,
    CF_CDIR  = 4'd2,
    CF_BRA   = 4'd3,
    CF_BCOND = 4'd4,
    CF_JREG  = 4'd5,
    CF_CREG  = 4'd6,
    CF_RET   = 4'd7,
    CF_ERET  = 4'd8,
    CF_BRET  = 4'd9,
    CF_PCCAP = 4'd10
  } cf_op_e;

  typedef enum logic [2:0] {
    CND_GE  = 3'd0,
    CND_LT  = 3'd1,
    CND_NE  = 3'd2,
    CND_EQ  = 3'd3,
    CND_GEU = 3'd4,
    CND_LTU = 3'd5
  } cond_e;

  localparam logic [3:0] KIND_SEQ = 4'b0001;
  localparam logic [3:0] KIND_BR  = 4'b0010;
  localparam logic [3:0] KIND_JMP = 4'b0100;
  localparam logic [3:0] KIND_RET = 4'b1000;
endpackage

// File: rtl/npc_cond_eval.sv
module npc_cond_eval #(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  input  logic [2:0]      cond,
  output logic            hit
);
  import npc_pkg::*;

  logic eq, lt_s, lt_u;

  assign eq   = (a == b);
  assign lt_s = ($signed(a) < $signed(b));
  assign lt_u = (a < b);

  always_comb begin
    case (cond)
      CND_GE:  hit = !lt_s;
      CND_LT:  hit = lt_s;
      CND_NE:  hit = !eq;
      CND_EQ:  hit = eq;
      CND_GEU: hit = !lt_u;
      CND_LTU: hit = lt_u;
      default: hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/npc_target_gen.sv
module npc_target_gen #(
  parameter int XLEN   = 32,
  parameter int KEEP_W = 4,
  parameter int BIMM_W = 16,
  parameter int JIMM_W = XLEN - KEEP_W - 2
) (
  input  logic [XLEN-1:0]   pc,
  input  logic [BIMM_W-1:0] imm_b,
  input  logic [JIMM_W-1:0] imm_j,
  output logic [XLEN-1:0]   seq_pc,
  output logic [XLEN-1:0]   jump_pc,
  output logic [XLEN-1:0]   branch_pc
);
  localparam int EXT_W = XLEN - BIMM_W;
  localparam logic [XLEN-1:0] WORD_MASK = ~XLEN'(3);

  logic [XLEN-1:0] offs;

  assign seq_pc  = pc + XLEN'(4);
  assign jump_pc = {pc[XLEN-1 -: KEEP_W], imm_j, 2'b00};

  generate
    if (EXT_W > 0) begin : g_ext
      assign offs = {{EXT_W{imm_b[BIMM_W-1]}}, imm_b} & WORD_MASK;
    end else begin : g_noext
      assign offs = imm_b[XLEN-1:0] & WORD_MASK;
    end
  endgenerate

  assign branch_pc = seq_pc + offs;
endmodule

// File: rtl/npc_unit.sv
module npc_unit #(
  parameter int XLEN   = 32,
  parameter int KEEP_W = 4,
  parameter int BIMM_W = 16,
  parameter int REGW   = 5,
  parameter int JIMM_W = XLEN - KEEP_W - 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [3:0]        op,
  input  logic [2:0]        cond,
  input  logic [XLEN-1:0]   pc,
  input  logic [BIMM_W-1:0] imm_b,
  input  logic [JIMM_W-1:0] imm_j,
  input  logic [REGW-1:0]   idx_a,
  input  logic [REGW-1:0]   idx_b,
  input  logic [REGW-1:0]   idx_c,
  input  logic [XLEN-1:0]   opnd_a,
  input  logic [XLEN-1:0]   opnd_b,
  input  logic [XLEN-1:0]   ra_val,
  input  logic [XLEN-1:0]   ea_val,
  input  logic [XLEN-1:0]   ba_val,
  output logic              out_valid,
  output logic [XLEN-1:0]   npc,
  output logic              taken,
  output logic [3:0]        kind,
  output logic              link_we,
  output logic [REGW-1:0]   link_idx,
  output logic [XLEN-1:0]   link_val,
  output logic              status_restore
);
  import npc_pkg::*;

  localparam logic [REGW-1:0] RA_IDX = {REGW{1'b1}};

  cf_op_e          op_e;
  logic [XLEN-1:0] a_eff, b_eff;
  logic [XLEN-1:0] seq_pc, jump_pc, branch_pc;
  logic            cond_hit;

  logic [XLEN-1:0] n_npc, n_val;
  logic            n_taken, n_we, n_rst;
  logic [3:0]      n_kind;
  logic [REGW-1:0] n_idx;

  assign op_e  = cf_op_e'(op);
  assign a_eff = (idx_a == '0) ? '0 : opnd_a;
  assign b_eff = (idx_b == '0) ? '0 : opnd_b;

  npc_target_gen #(
    .XLEN(XLEN), .KEEP_W(KEEP_W), .BIMM_W(BIMM_W), .JIMM_W(JIMM_W)
  ) u_tgt (
    .pc(pc), .imm_b(imm_b), .imm_j(imm_j),
    .seq_pc(seq_pc), .jump_pc(jump_pc), .branch_pc(branch_pc)
  );

  npc_cond_eval #(.XLEN(XLEN)) u_cmp (
    .a(a_eff), .b(b_eff), .cond(cond), .hit(cond_hit)
  );

  always_comb begin
    n_npc   = seq_pc;
    n_taken = 1'b0;
    n_kind  = KIND_SEQ;
    n_we    = 1'b0;
    n_idx   = '0;
    n_val   = seq_pc;
    n_rst   = 1'b0;
    case (op_e)
      CF_JDIR: begin
        n_npc = jump_pc; n_taken = 1'b1; n_kind = KIND_JMP;
      end
      CF_CDIR: begin
        n_npc = jump_pc; n_taken = 1'b1; n_kind = KIND_JMP;
        n_we  = 1'b1;    n_idx = RA_IDX;
      end
      CF_BRA: begin
        n_npc = branch_pc; n_taken = 1'b1; n_kind = KIND_BR;
      end
      CF_BCOND: begin
        n_kind = KIND_BR;
        if (cond_hit) begin
          n_npc = branch_pc; n_taken = 1'b1;
        end
      end
      CF_JREG: begin
        n_npc = a_eff; n_taken = 1'b1; n_kind = KIND_JMP;
      end
      CF_CREG: begin
        n_npc = a_eff; n_taken = 1'b1; n_kind = KIND_JMP;
        n_we  = 1'b1;  n_idx = RA_IDX;
      end
      CF_RET: begin
        n_npc = ra_val; n_taken = 1'b1; n_kind = KIND_RET;
      end
      CF_ERET: begin
        n_npc = ea_val; n_taken = 1'b1; n_kind = KIND_RET; n_rst = 1'b1;
      end
      CF_BRET: begin
        n_npc = ba_val; n_taken = 1'b1; n_kind = KIND_RET;
      end
      CF_PCCAP: begin
        n_we = 1'b1; n_idx = idx_c;
      end
      default: ;
    endcase
    // writes aimed at the hard-wired zero register are dropped
    if (n_idx == '0) n_we = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid      <= 1'b0;
      npc            <= '0;
      taken          <= 1'b0;
      kind           <= '0;
      link_we        <= 1'b0;
      link_idx       <= '0;
      link_val       <= '0;
      status_restore <= 1'b0;
    end else begin
      out_valid      <= in_valid;
      taken          <= in_valid & n_taken;
      link_we        <= in_valid & n_we;
      status_restore <= in_valid & n_rst;
      if (in_valid) begin
        npc      <= n_npc;
        kind     <= n_kind;
        link_idx <= n_idx;
        link_val <= n_val;
      end
    end
  end

  p_seq_step_r1: assert property (@(posedge clk) disable iff (rst)
    (out_valid && kind == KIND_SEQ) |-> (npc == $past(pc) + XLEN'(4) && !taken));

  p_call_link_r3: assert property (@(posedge clk) disable iff (rst)
    ($past(in_valid) && $past(op) == CF_CDIR) |->
      (link_we && link_idx == RA_IDX && link_val == $past(pc) + XLEN'(4)));

  p_restore_ret_r6: assert property (@(posedge clk) disable iff (rst)
    status_restore |-> (kind == KIND_RET && taken && out_valid));

  p_no_zero_write_r9: assert property (@(posedge clk) disable iff (rst)
    link_we |-> (link_idx != '0));

  p_kind_onehot_r11: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> ($countones(kind) == 1));

  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> (!taken && !link_we && !status_restore));
endmodule

// File: tb/test_npc_unit.sv
module test_npc_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [3:0]  op = '0;
  logic [2:0]  cond = '0;
  logic [31:0] pc = '0;
  logic [15:0] imm_b = '0;
  logic [25:0] imm_j = '0;
  logic [4:0]  idx_a = '0, idx_b = '0, idx_c = '0;
  logic [31:0] opnd_a = '0, opnd_b = '0, ra_val = '0, ea_val = '0, ba_val = '0;
  logic        out_valid, taken, link_we, status_restore;
  logic [31:0] npc, link_val;
  logic [3:0]  kind;
  logic [4:0]  link_idx;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  npc_unit i_npc_unit (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op(op), .cond(cond), .pc(pc),
    .imm_b(imm_b), .imm_j(imm_j), .idx_a(idx_a), .idx_b(idx_b), .idx_c(idx_c),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .ra_val(ra_val), .ea_val(ea_val),
    .ba_val(ba_val), .out_valid(out_valid), .npc(npc), .taken(taken),
    .kind(kind), .link_we(link_we), .link_idx(link_idx), .link_val(link_val),
    .status_restore(status_restore)
  );

  logic [31:0] corner [6] = '{32'h0, 32'h1, 32'hFFFF_FFFF, 32'h7FFF_FFFF,
                              32'h8000_0000, 32'h5};
  logic [31:0] pcs [5] = '{32'h0, 32'h1000_0000, 32'hF000_0FFC, 32'h7FFF_FFFC,
                           32'hFFFF_FFFC};
  logic [15:0] bimms [6] = '{16'h0000, 16'h0007, 16'h7FFF, 16'h8000, 16'hFFFF,
                             16'h0104};
  logic [25:0] jimms [4] = '{26'h0, 26'h1, 26'h3FF_FFFF, 26'h2AA_AAAA};

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h (op=%0d cond=%0d pc=%h)",
               req, what, act, exp, op, cond, pc);
    end
  endtask

  function automatic string req_of(input logic [3:0] o);
    case (o)
      4'd1: return "R2";  4'd2: return "R3";
      4'd3: return "R4";  4'd4: return "R5";
      4'd5, 4'd6: return "R7";
      4'd7, 4'd8, 4'd9: return "R6";
      4'd10: return "R8";
      default: return "R1";
    endcase
  endfunction

  // independent reference computed from the requirement text
  task automatic apply_and_check();
    logic [31:0] e_npc, e_val, av, bv, seqp, offs;
    logic        e_taken, e_we, e_rst, hit;
    logic [3:0]  e_kind;
    logic [4:0]  e_idx;
    string       rq;
    av = (idx_a == 0) ? 32'd0 : opnd_a;
    bv = (idx_b == 0) ? 32'd0 : opnd_b;
    seqp = pc + 32'd4;
    offs = (imm_b[15] ? (32'hFFFF_0000 | 32'(imm_b)) : 32'(imm_b)) & 32'hFFFF_FFFC;
    case (cond)
      3'd0: hit = $signed(av) >= $signed(bv);
      3'd1: hit = $signed(av) < $signed(bv);
      3'd2: hit = av != bv;
      3'd3: hit = av == bv;
      3'd4: hit = av >= bv;
      3'd5: hit = av < bv;
      default: hit = 1'b0;
    endcase
    e_npc = seqp; e_taken = 0; e_kind = 4'd1; e_we = 0; e_idx = 0; e_val = seqp; e_rst = 0;
    case (op)
      4'd1, 4'd2: begin
        e_npc = (pc & 32'hF000_0000) | (32'(imm_j) * 4); e_taken = 1; e_kind = 4'd4;
        if (op == 4'd2) begin e_we = 1; e_idx = 5'd31; end
      end
      4'd3: begin e_npc = seqp + offs; e_taken = 1; e_kind = 4'd2; end
      4'd4: begin e_kind = 4'd2; if (hit) begin e_npc = seqp + offs; e_taken = 1; end end
      4'd5, 4'd6: begin
        e_npc = av; e_taken = 1; e_kind = 4'd4;
        if (op == 4'd6) begin e_we = 1; e_idx = 5'd31; end
      end
      4'd7: begin e_npc = ra_val; e_taken = 1; e_kind = 4'd8; end
      4'd8: begin e_npc = ea_val; e_taken = 1; e_kind = 4'd8; e_rst = 1; end
      4'd9: begin e_npc = ba_val; e_taken = 1; e_kind = 4'd8; end
      4'd10: begin e_idx = idx_c; e_we = (idx_c != 0); end
      default: ;
    endcase
    rq = req_of(op);
    in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check(out_valid == 1'b1, "R1", "out_valid", 32'(out_valid), 32'd1);
    check(npc == e_npc, rq, "npc", npc, e_npc);
    check(taken == e_taken, rq, "taken", 32'(taken), 32'(e_taken));
    check(kind == e_kind, "R11", "kind", 32'(kind), 32'(e_kind));
    check(link_we == e_we, (op == 4'd10 && idx_c == 0) ? "R9" : rq, "link_we",
          32'(link_we), 32'(e_we));
    if (e_we) begin
      check(link_idx == e_idx, rq, "link_idx", 32'(link_idx), 32'(e_idx));
      check(link_val == e_val, rq, "link_val", link_val, e_val);
    end
    check(status_restore == e_rst, "R6", "status_restore",
          32'(status_restore), 32'(e_rst));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    // R12: reset state
    check(out_valid == 0 && taken == 0 && link_we == 0 && status_restore == 0,
          "R12", "strobes", {out_valid, taken, link_we, status_restore}, 0);
    check(npc == 0, "R12", "npc", npc, 0);
    check(kind == 0 && link_idx == 0 && link_val == 0, "R12", "kind/link",
          {kind, link_idx, link_val[22:0]}, 0);
    rst = 1'b0;
    ra_val = 32'h1234_5678; ea_val = 32'h0BAD_F00C; ba_val = 32'hCAFE_0004;

    // R5 and R10: condition sweep over corner operand pairs
    idx_a = 5'd3; idx_b = 5'd4; op = 4'd4;
    for (int c = 0; c < 8; c++)
      for (int i = 0; i < 6; i++)
        for (int j = 0; j < 6; j++)
          for (int p = 0; p < 3; p++) begin
            cond = 3'(c); opnd_a = corner[i]; opnd_b = corner[j];
            pc = pcs[p + 2]; imm_b = bimms[(i + j + p) % 6];
            apply_and_check();
          end

    // R10: zero register indices force zero operands
    for (int z = 0; z < 3; z++)
      for (int c = 0; c < 6; c++)
        for (int i = 1; i < 6; i++) begin
          idx_a = (z == 1) ? 5'd0 : 5'd2; idx_b = (z == 2) ? 5'd0 : 5'd6;
          cond = 3'(c); opnd_a = corner[i]; opnd_b = corner[6 - i];
          pc = 32'h0000_4000; imm_b = 16'h0040; op = 4'd4;
          apply_and_check();
          op = 4'd5; apply_and_check();
          op = 4'd6; apply_and_check();
        end

    // R1-class sweep: every class code against PCs and immediates
    idx_a = 5'd9; idx_b = 5'd10; cond = 3'd3;
    for (int o = 0; o < 16; o++)
      for (int p = 0; p < 5; p++)
        for (int k = 0; k < 6; k++)
          for (int c = 0; c < 8; c += 7) begin
            op = 4'(o); pc = pcs[p]; imm_b = bimms[k]; imm_j = jimms[k % 4];
            opnd_a = corner[k]; opnd_b = corner[(k + p) % 6];
            idx_c = (c == 0) ? 5'd0 : 5'd7;
            apply_and_check();
          end

    // R11: idle cycle after traffic quiets the strobes
    in_valid = 1'b0;
    @(posedge clk); @(negedge clk);
    check(out_valid == 0 && taken == 0 && link_we == 0 && status_restore == 0,
          "R11", "idle strobes", {out_valid, taken, link_we, status_restore}, 0);

    // R12: reset mid-stream clears again
    op = 4'd8; in_valid = 1'b1; rst = 1'b1;
    @(posedge clk); @(negedge clk);
    check(out_valid == 0 && status_restore == 0 && npc == 0, "R12", "re-reset",
          npc, 0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule